// File: doc/BRIEF.md
# Shared-Level Word Registry

The block sits in the shared last-level cache. It keeps one entry per word, and each entry holds one of two things. If the word is in the Valid state, the entry holds the current data. If the word is in the Registered state, the entry holds the identity of the one core that owns the only up-to-date copy. The data array is also the directory. There is no sharer list and no second tag array, and the block never invalidates anything.

Cores send three kinds of request: read, registration and writeback. The block handles one request per cycle and answers it one clock later on one of three reply channels:
- an acknowledgement to the requester,
- a data reply to the requester, or
- a forward, which sends the read on to the registered owner together with the requester's identity.

A request sees every change made by the request before it. The store with the Valid and Registered word states, the request decode and the output registers are all inside the block. Backing memory and the network are not.

Top module: `llc_word_registry`

## Requirements
- R1: After reset every word is in the Valid state and holds zero, and all three reply valids are low.
- R2: A read (`req_op` = 1) of a Valid word raises `rsp_valid` on the next cycle. `rsp_core` is the requester and `rsp_data` is the stored word.
- R3: A registration (`req_op` = 2) raises `ack_valid` on the next cycle with `ack_core` equal to the requester. The word then enters the Registered state with the requester as owner. Any core from 0 to 15 can be the owner.
- R4: A read of a Registered word raises `fwd_valid` on the next cycle. `fwd_owner` is the owner, `fwd_requester` is the reader and `fwd_addr` is the word address. No data reply is sent.
- R5: A registration of a word that is already Registered replaces the owner. The only message is the acknowledgement to the new owner, and the previous owner receives nothing.
- R6: A writeback (`req_op` = 3) from the registered owner is acknowledged to the writer. The word returns to Valid and holds the written data.
- R7: A writeback from a core that is not the owner, or a writeback to a word that is already Valid, is acknowledged but leaves the word unchanged.
- R8: Each request with `req_valid` high and a nonzero `req_op` produces exactly one reply on the next cycle. A cycle with `req_valid` low, or with `req_op` = 0, produces no reply. No two reply valids are ever high together.
- R9: A request sees the effect of the request accepted in the cycle before it.
- R10: A request changes only the word it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 none, 1 read, 2 registration, 3 writeback |
| req_core | input | 4 | Requesting core |
| req_addr | input | 4 | Word index |
| req_data | input | 32 | Writeback data |
| ack_valid | output | 1 | Acknowledgement issued |
| ack_core | output | 4 | Core that receives the acknowledgement |
| rsp_valid | output | 1 | Data reply issued |
| rsp_core | output | 4 | Core that receives the data |
| rsp_data | output | 32 | Returned word |
| fwd_valid | output | 1 | Read forwarded to the owner |
| fwd_owner | output | 4 | Registered owner that receives the forward |
| fwd_requester | output | 4 | Core that issued the read |
| fwd_addr | output | 4 | Word being read |

## Verification
In the same clock edge the block can both commit a state change to a word and issue the reply to the previous request, while the next request already looks up that same word. The bench provokes this by sending requests with no gap between them. It registers a word and reads it on the very next cycle, re-registers it and reads it again, and sends a writeback followed at once by a read. Each reply is judged at the ports. The bench checks which channel carries the reply, whether the forward goes to the newest owner, and whether the data returned matches the writeback that was just accepted.

// File: rtl/llc_reg_pkg.sv
package llc_reg_pkg;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_READ      = 2'd1,
        OP_REGISTER  = 2'd2,
        OP_WRITEBACK = 2'd3
    } op_e;

    typedef enum logic {
        WS_VALID = 1'b0,
        WS_REG   = 1'b1
    } wstate_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_DATA = 2'd1,
        ACT_ACK  = 2'd2,
        ACT_FWD  = 2'd3
    } act_e;

endpackage

// File: rtl/llc_reg_store.sv
module llc_reg_store
    import llc_reg_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output wstate_e           rd_state,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  wstate_e           wr_state,
    input  logic [DATA_W-1:0] wr_word
);

    wstate_e           st_q   [WORDS];
    logic [DATA_W-1:0] word_q [WORDS];

    // Each entry holds either data or an owner id, as its state says.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                st_q[i]   <= WS_VALID;
                word_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_addr]   <= wr_state;
            word_q[wr_addr] <= wr_word;
        end
    end

    assign rd_state = st_q[rd_addr];
    assign rd_word  = word_q[rd_addr];

endmodule

// File: rtl/llc_reg_decode.sv
module llc_reg_decode
    import llc_reg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CORE_W = 4
) (
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic [CORE_W-1:0] req_core,
    input  logic [DATA_W-1:0] req_data,
    input  wstate_e           cur_state,
    input  logic [DATA_W-1:0] cur_word,
    output act_e              act,
    output logic              wr_en,
    output wstate_e           wr_state,
    output logic [DATA_W-1:0] wr_word,
    output logic [CORE_W-1:0] owner
);

    assign owner = cur_word[CORE_W-1:0];

    always_comb begin
        act      = ACT_NONE;
        wr_en    = 1'b0;
        wr_state = cur_state;
        wr_word  = cur_word;
        if (req_valid) begin
            unique case (req_op)
                OP_READ: begin
                    act = (cur_state == WS_REG) ? ACT_FWD : ACT_DATA;
                end
                OP_REGISTER: begin
                    act      = ACT_ACK;
                    wr_en    = 1'b1;
                    wr_state = WS_REG;
                    wr_word  = DATA_W'(req_core);
                end
                OP_WRITEBACK: begin
                    act = ACT_ACK;
                    if (cur_state == WS_REG && owner == req_core) begin
                        wr_en    = 1'b1;
                        wr_state = WS_VALID;
                        wr_word  = req_data;
                    end
                end
                default: act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/llc_reg_reply.sv
module llc_reg_reply
    import llc_reg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CORE_W = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] owner,
    input  logic [DATA_W-1:0] word,
    output logic              ack_valid,
    output logic [CORE_W-1:0] ack_core,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fwd_valid,
    output logic [CORE_W-1:0] fwd_owner,
    output logic [CORE_W-1:0] fwd_requester,
    output logic [ADDR_W-1:0] fwd_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid     <= 1'b0;
            ack_core      <= '0;
            rsp_valid     <= 1'b0;
            rsp_core      <= '0;
            rsp_data      <= '0;
            fwd_valid     <= 1'b0;
            fwd_owner     <= '0;
            fwd_requester <= '0;
            fwd_addr      <= '0;
        end else begin
            ack_valid <= (act == ACT_ACK);
            rsp_valid <= (act == ACT_DATA);
            fwd_valid <= (act == ACT_FWD);
            unique case (act)
                ACT_ACK:  ack_core <= req_core;
                ACT_DATA: begin
                    rsp_core <= req_core;
                    rsp_data <= word;
                end
                ACT_FWD: begin
                    fwd_owner     <= owner;
                    fwd_requester <= req_core;
                    fwd_addr      <= req_addr;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/llc_word_registry.sv
module llc_word_registry
    import llc_reg_pkg::*;
#(
    parameter int WORDS     = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_CORES = 16,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int CORE_W = $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ack_valid,
    output logic [CORE_W-1:0] ack_core,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fwd_valid,
    output logic [CORE_W-1:0] fwd_owner,
    output logic [CORE_W-1:0] fwd_requester,
    output logic [ADDR_W-1:0] fwd_addr
);

    wstate_e           cur_state;
    logic [DATA_W-1:0] cur_word;
    act_e              act;
    logic              wr_en;
    wstate_e           wr_state;
    logic [DATA_W-1:0] wr_word;
    logic [CORE_W-1:0] owner;

    llc_reg_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (req_addr),
        .rd_state (cur_state),
        .rd_word  (cur_word),
        .wr_en    (wr_en),
        .wr_addr  (req_addr),
        .wr_state (wr_state),
        .wr_word  (wr_word)
    );

    llc_reg_decode #(.DATA_W(DATA_W), .CORE_W(CORE_W)) u_decode (
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_core  (req_core),
        .req_data  (req_data),
        .cur_state (cur_state),
        .cur_word  (cur_word),
        .act       (act),
        .wr_en     (wr_en),
        .wr_state  (wr_state),
        .wr_word   (wr_word),
        .owner     (owner)
    );

    llc_reg_reply #(.DATA_W(DATA_W), .CORE_W(CORE_W), .ADDR_W(ADDR_W)) u_reply (
        .clk           (clk),
        .rst_n         (rst_n),
        .act           (act),
        .req_core      (req_core),
        .req_addr      (req_addr),
        .owner         (owner),
        .word          (cur_word),
        .ack_valid     (ack_valid),
        .ack_core      (ack_core),
        .rsp_valid     (rsp_valid),
        .rsp_core      (rsp_core),
        .rsp_data      (rsp_data),
        .fwd_valid     (fwd_valid),
        .fwd_owner     (fwd_owner),
        .fwd_requester (fwd_requester),
        .fwd_addr      (fwd_addr)
    );

endmodule

// File: rtl/llc_word_registry_chk.sv
module llc_word_registry_chk #(
    parameter int CORE_W = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [CORE_W-1:0] req_core,
    input logic [ADDR_W-1:0] req_addr,
    input logic              ack_valid,
    input logic [CORE_W-1:0] ack_core,
    input logic              rsp_valid,
    input logic [CORE_W-1:0] rsp_core,
    input logic              fwd_valid,
    input logic [CORE_W-1:0] fwd_requester,
    input logic [ADDR_W-1:0] fwd_addr
);

    p_one_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_valid, rsp_valid, fwd_valid}));

    p_reply_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd0) |=> (ack_valid || rsp_valid || fwd_valid));

    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_op == 2'd0) |=> !(ack_valid || rsp_valid || fwd_valid));

    p_reg_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2) |=> (ack_valid && ack_core == $past(req_core)));

    p_wb_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> (ack_valid && ack_core == $past(req_core)));

    p_read_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1) |=> (rsp_valid ? rsp_core == $past(req_core) : fwd_valid));

    p_fwd_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1) |=>
            (!fwd_valid || (fwd_requester == $past(req_core) && fwd_addr == $past(req_addr))));

endmodule

bind llc_word_registry llc_word_registry_chk #(.CORE_W(CORE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_core      (req_core),
    .req_addr      (req_addr),
    .ack_valid     (ack_valid),
    .ack_core      (ack_core),
    .rsp_valid     (rsp_valid),
    .rsp_core      (rsp_core),
    .fwd_valid     (fwd_valid),
    .fwd_requester (fwd_requester),
    .fwd_addr      (fwd_addr)
);

// File: tb/llc_word_registry_tb.sv
module llc_word_registry_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [3:0]  req_core = '0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic        ack_valid, rsp_valid, fwd_valid;
    logic [3:0]  ack_core, rsp_core, fwd_owner, fwd_requester, fwd_addr;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    llc_word_registry u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_core(req_core), .req_addr(req_addr), .req_data(req_data),
        .ack_valid(ack_valid), .ack_core(ack_core), .rsp_valid(rsp_valid),
        .rsp_core(rsp_core), .rsp_data(rsp_data), .fwd_valid(fwd_valid),
        .fwd_owner(fwd_owner), .fwd_requester(fwd_requester), .fwd_addr(fwd_addr)
    );

    // kinds: 0 none, 1 data, 2 ack, 3 forward (exp_data[3:0] = requester)
    localparam int NV = 16;
    // {op, core, addr, data, kind, exp_core, exp_data, req tag}
    localparam logic [83:0] VEC [NV] = '{
        {2'd1, 4'd3,  4'd5,  32'h0,        2'd1, 4'd3,  32'h0,        4'd2},
        {2'd3, 4'd2,  4'd5,  32'h0000AAAA, 2'd2, 4'd2,  32'h0,        4'd7},
        {2'd1, 4'd1,  4'd5,  32'h0,        2'd1, 4'd1,  32'h0,        4'd7},
        {2'd2, 4'd7,  4'd5,  32'h0,        2'd2, 4'd7,  32'h0,        4'd3},
        {2'd1, 4'd2,  4'd5,  32'h0,        2'd3, 4'd7,  32'h2,        4'd4},
        {2'd2, 4'd9,  4'd5,  32'h0,        2'd2, 4'd9,  32'h0,        4'd5},
        {2'd3, 4'd7,  4'd5,  32'h00001111, 2'd2, 4'd7,  32'h0,        4'd7},
        {2'd1, 4'd4,  4'd5,  32'h0,        2'd3, 4'd9,  32'h4,        4'd5},
        {2'd1, 4'd4,  4'd6,  32'h0,        2'd1, 4'd4,  32'h0,        4'd10},
        {2'd3, 4'd9,  4'd5,  32'hCAFE0001, 2'd2, 4'd9,  32'h0,        4'd6},
        {2'd1, 4'd0,  4'd5,  32'h0,        2'd1, 4'd0,  32'hCAFE0001, 4'd6},
        {2'd2, 4'd15, 4'd15, 32'h0,        2'd2, 4'd15, 32'h0,        4'd3},
        {2'd1, 4'd0,  4'd15, 32'h0,        2'd3, 4'd15, 32'h0,        4'd9},
        {2'd3, 4'd15, 4'd15, 32'hFFFFFFFF, 2'd2, 4'd15, 32'h0,        4'd6},
        {2'd1, 4'd15, 4'd15, 32'h0,        2'd1, 4'd15, 32'hFFFFFFFF, 4'd9},
        {2'd0, 4'd1,  4'd1,  32'h0,        2'd0, 4'd0,  32'h0,        4'd8}
    };

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
            5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
            9: return "R9"; default: return "R10";
        endcase
    endfunction

    task automatic drive(input logic v, input logic [1:0] op, input logic [3:0] c,
                         input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = v; req_op = op; req_core = c; req_addr = a; req_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic judge(input string tag, input logic [1:0] kind, input logic [3:0] ecore,
                         input logic [31:0] edata, input logic [3:0] eaddr);
        logic [1:0] got;
        logic ok;
        got = ack_valid ? 2'd2 : rsp_valid ? 2'd1 : fwd_valid ? 2'd3 : 2'd0;
        ok = (ack_valid + rsp_valid + fwd_valid <= 1) && (got == kind);
        if (ok) case (kind)
            2'd1: ok = (rsp_core == ecore) && (rsp_data == edata);
            2'd2: ok = (ack_core == ecore);
            2'd3: ok = (fwd_owner == ecore) && (fwd_requester == edata[3:0]) && (fwd_addr == eaddr);
            default: ;
        endcase
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got valids a%0b r%0b f%0b ack_core=%0d rsp_core=%0d rsp_data=%h fwd=%0d/%0d/%0d, expected kind=%0d core=%0d data=%h addr=%0d",
                     tag, ack_valid, rsp_valid, fwd_valid, ack_core, rsp_core, rsp_data,
                     fwd_owner, fwd_requester, fwd_addr, kind, ecore, edata, eaddr);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        judge("R1", 2'd0, 4'd0, 32'h0, 4'd0);           // R1 replies low in reset
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'd0, 4'd0, 4'd0, 32'h0);
        judge("R1", 2'd0, 4'd0, 32'h0, 4'd0);

        // table walked back to back: each row also exercises R9
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][83:82], VEC[i][81:78], VEC[i][77:74], VEC[i][73:42]);
            judge(tag_name(int'(VEC[i][3:0])), VEC[i][41:40], VEC[i][39:36],
                  VEC[i][35:4], VEC[i][77:74]);
        end

        // R8: no request, no reply
        drive(1'b0, 2'd1, 4'd3, 4'd5, 32'h0);
        judge("R8", 2'd0, 4'd0, 32'h0, 4'd0);

        // R9: register then immediately read, then writeback then immediately read
        drive(1'b1, 2'd2, 4'd12, 4'd0, 32'h0);
        judge("R9", 2'd2, 4'd12, 32'h0, 4'd0);
        drive(1'b1, 2'd1, 4'd1, 4'd0, 32'h0);
        judge("R9", 2'd3, 4'd12, 32'h1, 4'd0);
        drive(1'b1, 2'd3, 4'd12, 4'd0, 32'h12345678);
        judge("R9", 2'd2, 4'd12, 32'h0, 4'd0);
        drive(1'b1, 2'd1, 4'd2, 4'd0, 32'h0);
        judge("R9", 2'd1, 4'd2, 32'h12345678, 4'd0);

        // R10: neighbours of touched words still hold reset zero
        drive(1'b1, 2'd1, 4'd8, 4'd1, 32'h0);
        judge("R10", 2'd1, 4'd8, 32'h0, 4'd1);
        drive(1'b1, 2'd1, 4'd8, 4'd14, 32'h0);
        judge("R10", 2'd1, 4'd8, 32'h0, 4'd14);

        // R1: a fresh reset returns written words to zero
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 2'd1, 4'd3, 4'd5, 32'h0);
        judge("R1", 2'd1, 4'd3, 32'h0, 4'd5);
        drive(1'b1, 2'd1, 4'd3, 4'd15, 32'h0);
        judge("R1", 2'd1, 4'd3, 32'h0, 4'd15);

        @(negedge clk);
        req_valid = 1'b0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule